// File: doc/BRIEF.md
# Layer DMA Descriptor Fetcher

This block is the memory-side front end of one display layer. It walks a chain of three-word descriptors in memory. Each descriptor names a frame buffer, carries a control word and points to the next descriptor. The block then streams the frame's words into an external pixel FIFO, using fixed four-beat read bursts. A descriptor whose next pointer names itself makes one frame repeat for as long as the channel runs. Two enables gate the chain: the channel enable starts and stops the walk, and the update enable decides whether a new descriptor may be taken at a frame boundary.

All memory traffic goes through one request/response port with a valid/ready request and an unthrottled response beat stream. The FIFO side is a write strobe with data, and the FIFO reports its free entries back. Three sticky status flags record address loads, descriptor loads and frame completions. Each flag is armed by a bit of the descriptor's control word and cleared by writing one.

Top module: `layer_desc_fetch`

## Requirements
- R1: While reset is held and after it is released, mem_req_valid, fifo_wr_en and all three flags are 0 until the channel is enabled.
- R2: When chan_en is seen high while idle, the block reads a 4-beat burst at head_ptr. Beat 0 is the frame buffer address, beat 1 the control word and beat 2 the next-descriptor pointer; beat 3 is discarded.
- R3: After a descriptor is loaded, frame_words words (a nonzero multiple of 4) are read as 4-beat bursts at the buffer address plus 0, 4, 8 and so on. Every returned word is written to the FIFO exactly once, in order.
- R4: A descriptor whose next pointer equals its own address is fetched again at every frame end, and the same frame repeats without limit.
- R5: At a frame end, with control bit 0 (fetch enable) set and upd_en high, the next descriptor is read from the stored next pointer, so a chain of descriptors is followed.
- R6: At a frame end, with control bit 0 clear or upd_en low, no descriptor is read, and the same buffer range is streamed again.
- R7: A pixel burst is requested only while fifo_free is at least 4. Descriptor reads do not depend on fifo_free.
- R8: Once raised, mem_req_valid stays high with an unchanged mem_req_addr until mem_req_ready is seen.
- R9: Flag bit 0 (address loaded) is set when a descriptor load completes if control bit 1 is set. Flag bit 1 (descriptor loaded) is set at the same point if control bit 2 is set. Flag bit 2 (frame done) is set when the last word of a frame arrives if control bit 3 is set. A set flag stays set until cleared.
- R10: A one on a bit of flag_clr clears that flag on the next clock and leaves the other flags unchanged.
- R11: With chan_en low, the block issues no new request once its current burst ends. It returns to idle and waits for chan_en again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| upd_en | input | 1 | Permits a descriptor load at a frame end |
| head_ptr | input | AW | Address of the first descriptor |
| frame_words | input | LW | Frame length in words, a multiple of 4 |
| fifo_free | input | FW | Free entries in the pixel FIFO |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Word address of the first beat |
| mem_rsp_valid | input | 1 | Read beat valid |
| mem_rsp_data | input | DW | Read beat data |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | DW | FIFO write data |
| flags | output | 3 | Sticky status: bit0 address, bit1 descriptor, bit2 frame done |
| flag_clr | input | 3 | Write-one-to-clear for flags |

## Verification
The bench follows a self-pointing descriptor, a two-descriptor ring, a descriptor with fetch disabled and a run with upd_en low. A block that mixes up the two replay conditions re-reads descriptors or jumps to a stale buffer, and the request scoreboard shows this as a wrong address. Holding fifo_free at 3 and then raising it to exactly 4 exposes an off-by-one room test, which shows up as an early or missing pixel request. Memory back-pressure on every third cycle catches a request that drops or changes its address. The flag checks cover a disarmed enable that still sets a flag, and a partial clear that wipes a neighbouring flag. Checking for silence after chan_en drops catches a block that starts another frame or burst after being disabled.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRSP,
    ST_PREQ,
    ST_PRSP
  } ldf_state_e;

  // control word bit positions
  localparam int CB_FETCH   = 0;
  localparam int CB_IE_ADDR = 1;
  localparam int CB_IE_DSC  = 2;
  localparam int CB_IE_DONE = 3;
  localparam int CTRL_W     = 4;

  // flag positions
  localparam int FL_ADDR = 0;
  localparam int FL_DSC  = 1;
  localparam int FL_DONE = 2;
  localparam int NFLAG   = 3;
endpackage

// File: rtl/ldf_desc_capture.sv
module ldf_desc_capture
  import ldf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BW-1:0]     beat,
  input  logic [DW-1:0]     data,
  output logic [AW-1:0]     buf_addr,
  output logic [CTRL_W-1:0] ctrl,
  output logic [AW-1:0]     next_ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_addr <= '0;
      ctrl     <= '0;
      next_ptr <= '0;
    end else if (en) begin
      case (beat)
        BW'(0): buf_addr <= data[AW-1:0];
        BW'(1): ctrl     <= data[CTRL_W-1:0];
        BW'(2): next_ptr <= data[AW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ldf_flag_bank.sv
module ldf_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/layer_desc_fetch.sv
module layer_desc_fetch
  import ldf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LW         = 16,
  parameter int BURST      = 4,
  parameter int FIFO_DEPTH = 512,
  localparam int FW        = $clog2(FIFO_DEPTH + 1),
  localparam int BW        = $clog2(BURST)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             upd_en,
  input  logic [AW-1:0]    head_ptr,
  input  logic [LW-1:0]    frame_words,
  input  logic [FW-1:0]    fifo_free,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             fifo_wr_en,
  output logic [DW-1:0]    fifo_wr_data,
  output logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] flag_clr
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BURST - 1);
  localparam logic [LW-1:0] STEP_LEN  = LW'(BURST);
  localparam logic [AW-1:0] STEP_ADDR = AW'(BURST);

  ldf_state_e        st;
  logic [BW-1:0]     beat;
  logic [AW-1:0]     cur_addr;
  logic [LW-1:0]     remain;
  logic [AW-1:0]     buf_addr;
  logic [AW-1:0]     next_ptr;
  logic [CTRL_W-1:0] ctrl_q;
  logic              cap_en;
  logic              dsc_done;
  logic              frame_end;
  logic              room_ok;
  logic [NFLAG-1:0]  flag_set;

  assign cap_en    = (st == ST_DRSP) && mem_rsp_valid;
  assign dsc_done  = cap_en && (beat == LAST_BEAT);
  assign frame_end = (st == ST_PRSP) && mem_rsp_valid && (beat == LAST_BEAT)
                     && (remain == STEP_LEN);
  assign room_ok   = fifo_free >= FW'(BURST);

  always_comb begin
    flag_set          = '0;
    flag_set[FL_ADDR] = dsc_done && ctrl_q[CB_IE_ADDR];
    flag_set[FL_DSC]  = dsc_done && ctrl_q[CB_IE_DSC];
    flag_set[FL_DONE] = frame_end && ctrl_q[CB_IE_DONE];
  end

  ldf_desc_capture #(.AW(AW), .DW(DW), .BW(BW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .en       (cap_en),
    .beat     (beat),
    .data     (mem_rsp_data),
    .buf_addr (buf_addr),
    .ctrl     (ctrl_q),
    .next_ptr (next_ptr)
  );

  ldf_flag_bank #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      beat          <= '0;
      cur_addr      <= '0;
      remain        <= '0;
      fifo_wr_en    <= 1'b0;
      fifo_wr_data  <= '0;
    end else begin
      fifo_wr_en <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (chan_en) begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= head_ptr;
            st            <= ST_DREQ;
          end
        end
        ST_DREQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            beat          <= '0;
            st            <= ST_DRSP;
          end
        end
        ST_DRSP: begin
          if (mem_rsp_valid) begin
            beat <= beat + BW'(1);
            if (beat == LAST_BEAT) begin
              cur_addr <= buf_addr;
              remain   <= frame_words;
              st       <= ST_PREQ;
            end
          end
        end
        ST_PREQ: begin
          if (mem_req_valid) begin
            if (mem_req_ready) begin
              mem_req_valid <= 1'b0;
              beat          <= '0;
              st            <= ST_PRSP;
            end
          end else if (!chan_en) begin
            st <= ST_IDLE;
          end else if (room_ok) begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= cur_addr;
          end
        end
        ST_PRSP: begin
          if (mem_rsp_valid) begin
            fifo_wr_en   <= 1'b1;
            fifo_wr_data <= mem_rsp_data;
            beat         <= beat + BW'(1);
            if (beat == LAST_BEAT) begin
              if (remain == STEP_LEN) begin
                if (!chan_en) begin
                  st <= ST_IDLE;
                end else if (ctrl_q[CB_FETCH] && upd_en) begin
                  mem_req_valid <= 1'b1;
                  mem_req_addr  <= next_ptr;
                  st            <= ST_DREQ;
                end else begin
                  cur_addr <= buf_addr;
                  remain   <= frame_words;
                  st       <= ST_PREQ;
                end
              end else begin
                cur_addr <= cur_addr + STEP_ADDR;
                remain   <= remain - STEP_LEN;
                st       <= ST_PREQ;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldf_checker.sv
module ldf_checker
  import ldf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int FW    = 10,
  parameter int BURST = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [FW-1:0]    fifo_free,
  input logic             fifo_wr_en,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] flag_clr,
  input ldf_state_e       st
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req_valid && !fifo_wr_en && flags == '0)); // R1

  AST_WR_FROM_BEAT: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> ($past(mem_rsp_valid) && $past(st) == ST_PRSP)); // R3

  AST_PIX_ROOM: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PREQ && $rose(mem_req_valid)) |-> ($past(fifo_free) >= FW'(BURST))); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags[FL_DONE] && !flag_clr[FL_DONE]) |=> flags[FL_DONE]); // R9

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (flags[FL_DSC] && flag_clr[FL_DSC] && !(st == ST_DRSP && mem_rsp_valid))
      |=> !flags[FL_DSC]); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !mem_req_valid); // R11
endmodule

bind layer_desc_fetch ldf_checker #(.AW(AW), .FW(FW), .BURST(BURST)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .fifo_free     (fifo_free),
  .fifo_wr_en    (fifo_wr_en),
  .flags         (flags),
  .flag_clr      (flag_clr),
  .st            (st)
);

// File: tb/sim_layer_desc_fetch.sv
`timescale 1ns/1ps
module sim_layer_desc_fetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b1;
  logic [31:0] head_ptr = '0;
  logic [15:0] frame_words = 16'd8;
  logic [9:0]  fifo_free = 10'd512;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fifo_wr_en;
  logic [31:0] fifo_wr_data;
  logic [2:0]  flags;
  logic [2:0]  flag_clr = '0;
  logic        chan_en;

  int  checks = 0, failures = 0;
  int  acc_count = 0, stop_after = 0;
  bit  run = 0, done = 0;

  assign chan_en = run && (acc_count < stop_after);

  always #2.5 clk = ~clk;

  layer_desc_fetch u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .upd_en(upd_en),
    .head_ptr(head_ptr), .frame_words(frame_words), .fifo_free(fifo_free),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .flags(flags), .flag_clr(flag_clr)
  );

  logic [31:0] mem [256];
  logic [31:0] exp_addr[$];
  string       exp_addr_tag[$];
  logic [31:0] exp_data[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard driver side
  task automatic push_req(input logic [31:0] a, input string tag);
    exp_addr.push_back(a);
    exp_addr_tag.push_back(tag);
  endtask

  task automatic push_frame(input logic [31:0] b, input string tag);
    for (int k = 0; k < 8; k += 4) push_req(b + k, tag);
    for (int k = 0; k < 8; k++) exp_data.push_back(mem[(b + k) % 256]);
  endtask

  task automatic put_desc(input int at, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] n);
    mem[at] = b; mem[at+1] = c; mem[at+2] = n;
  endtask

  // memory model and monitors
  int          cyc = 0, pend = 0, base = 0;
  bit          acc_pend = 0, hold_chk = 0;
  logic [31:0] acc_addr = '0, hold_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (acc_pend) begin base = int'(acc_addr); pend = 4; acc_pend = 0; end
    if (pend > 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[(base + 4 - pend) % 256];
      pend--;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (hold_chk) begin
      chk(mem_req_valid && mem_req_addr == hold_addr, "R8", "request held under stall",
          mem_req_addr, hold_addr);
      hold_chk = 0;
    end
    mem_req_ready = (pend == 0) && !acc_pend && (cyc % 3 != 0);
    if (mem_req_valid) begin
      if (mem_req_ready) begin
        acc_pend = 1;
        acc_addr = mem_req_addr;
        acc_count++;
        if (exp_addr.size() == 0) begin
          chk(0, "R11", "unexpected request", mem_req_addr, '0);
        end else begin
          logic [31:0] ea;
          string tg;
          ea = exp_addr.pop_front();
          tg = exp_addr_tag.pop_front();
          chk(mem_req_addr == ea, tg, "request address", mem_req_addr, ea);
        end
      end else begin
        hold_chk  = 1;
        hold_addr = mem_req_addr;
      end
    end
    if (fifo_wr_en) begin
      if (exp_data.size() == 0) begin
        chk(0, "R3", "unexpected FIFO write", fifo_wr_data, '0);
      end else begin
        logic [31:0] ed;
        ed = exp_data.pop_front();
        chk(fifo_wr_data == ed, "R3", "FIFO word", fifo_wr_data, ed);
      end
    end
  end

  task automatic start(input int nreq);
    @(negedge clk);
    stop_after = acc_count + nreq;
    run = 1;
  endtask

  task automatic drain_and_stop();
    for (int t = 0; t < 4000 && (exp_addr.size() != 0 || exp_data.size() != 0); t++)
      @(negedge clk);
    chk(exp_addr.size() == 0 && exp_data.size() == 0, "R3", "scoreboard drained",
        exp_addr.size(), 0);
    repeat (40) @(negedge clk);
    chk(!mem_req_valid && acc_count == stop_after, "R11", "silent after disable",
        acc_count, stop_after);
    run = 0;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 | i;
    put_desc(8'h10, 32'h40, 32'hF, 32'h10);
    put_desc(8'h18, 32'hA0, 32'h4, 32'h18);
    put_desc(8'h20, 32'h60, 32'h1, 32'h30);
    put_desc(8'h30, 32'h80, 32'h1, 32'h20);

    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !fifo_wr_en && flags == 0, "R1", "outputs in reset",
        {mem_req_valid, fifo_wr_en, flags}, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!mem_req_valid && !fifo_wr_en && flags == 0, "R1", "outputs after reset",
        {mem_req_valid, fifo_wr_en, flags}, 0);

    // self-pointing descriptor, three frames
    head_ptr = 32'h10; upd_en = 1'b1;
    for (int f = 0; f < 3; f++) begin
      push_req(32'h10, f == 0 ? "R2" : "R4");
      push_frame(32'h40, "R4");
    end
    start(9);
    drain_and_stop();
    chk(flags == 3'b111, "R9", "all flags armed", flags, 3'b111);
    clear_flags(3'b010);
    chk(flags == 3'b101, "R10", "partial clear", flags, 3'b101);
    clear_flags(3'b101);
    chk(flags == 3'b000, "R10", "full clear", flags, 3'b000);

    // two-descriptor ring, no interrupt enables
    head_ptr = 32'h20;
    push_req(32'h20, "R5"); push_frame(32'h60, "R5");
    push_req(32'h30, "R5"); push_frame(32'h80, "R5");
    push_req(32'h20, "R5"); push_frame(32'h60, "R5");
    start(9);
    drain_and_stop();
    chk(flags == 3'b000, "R9", "disarmed flags stay clear", flags, 3'b000);

    // fetch bit clear: replay without refetch
    head_ptr = 32'h18;
    push_req(32'h18, "R6");
    for (int f = 0; f < 3; f++) push_frame(32'hA0, "R6");
    start(7);
    drain_and_stop();
    chk(flags == 3'b010, "R9", "only descriptor flag", flags, 3'b010);
    clear_flags(3'b111);

    // upd_en low plus FIFO room gating
    head_ptr = 32'h10; upd_en = 1'b0; fifo_free = 10'd3;
    push_req(32'h10, "R7");
    push_frame(32'h40, "R6"); push_frame(32'h40, "R6");
    start(5);
    for (int t = 0; t < 500 && acc_count < stop_after - 4; t++) @(negedge clk);
    chk(acc_count == stop_after - 4, "R7", "descriptor read with little room",
        acc_count, stop_after - 4);
    begin
      bit seen;
      seen = 0;
      repeat (60) begin @(negedge clk); if (mem_req_valid) seen = 1; end
      chk(!seen && acc_count == stop_after - 4, "R7", "no pixel burst at room 3",
          {31'd0, seen}, 0);
    end
    fifo_free = 10'd4;
    drain_and_stop();
    chk(flags == 3'b111, "R9", "flags after replay run", flags, 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule